// File: doc/BRIEF.md
# Prioritized restart interrupt controller

This block is the interrupt-control unit of a small 8-bit processor core. It watches five request lines: a non-maskable trap, three restart requests (7.5, 6.5 and 5.5) and a general request whose opcode comes from an external device. It holds three restart mask bits, the pending state of each restart request and the interrupt-enable flip-flop. When the core signals an instruction boundary, it picks the highest-priority request that may be taken. For a restart or trap it produces the restart vector address. For the general request it produces an acknowledge pulse.

The core writes a control byte from its accumulator into the block. This byte can reload the masks, clear the 7.5 edge latch and update a one-bit serial output latch. Each of these actions is gated by its own bit in the byte. The core can read a status byte at any time. That byte packs the masks, the enable flip-flop, the three pending flags and the serial input pin.

Request levels are registered once before arbitration. An accepted interrupt shows on the outputs as a one-cycle pulse in the cycle after the boundary strobe.

Top module: `irq_restart_ctrl`

## Requirements
- R1: After reset, all three masks are 1, the enable flip-flop is 0, the 7.5 latch is 0, the serial output is 0, and no take or acknowledge pulse is given. With all requests low and the serial input low, the status byte reads 07H.
- R2: Control-byte bit 3 (mask-set-enable) gates the masks. When bit 3 is 1, the masks load from bit 0 (5.5), bit 1 (6.5) and bit 2 (7.5). When bit 3 is 0, those three bits are ignored and the masks keep their values. A mask of 1 blocks its request.
- R3: A control write with bit 4 set clears the 7.5 latch. A rising edge on the 7.5 request in the same cycle takes precedence and leaves the latch set.
- R4: A control write with bit 6 set copies bit 7 to the serial output. A write with bit 6 clear leaves the serial output unchanged.
- R5: The status byte is laid out as follows:
  - bits 2:0 are the 7.5, 6.5 and 5.5 masks (bit 2 is 7.5, bit 0 is 5.5);
  - bit 3 is the enable flip-flop;
  - bit 4 is the registered 5.5 level;
  - bit 5 is the registered 6.5 level;
  - bit 6 is the 7.5 latch;
  - bit 7 is the serial input pin, passed through directly.
- R6: The enable command sets the enable flip-flop, and the disable command clears it. When both are given together, disable wins. Accepting any interrupt, including the trap, clears the flip-flop, and this also overrides the enable command.
- R7: A rising edge on the 7.5 request sets the 7.5 latch, which is visible in status bit 6 after that edge. The latch stays set after the request falls, until it is accepted or cleared by a write.
- R8: At a boundary, the order of priority is trap, then 7.5, then 6.5, then 5.5, then the general request. The trap ignores the masks and the enable flip-flop. Every other request needs the enable flip-flop set, and each restart also needs its mask clear.
- R9: An accepted trap or restart gives a one-cycle take pulse in the cycle after the boundary, with its vector address: trap 24H, 7.5 3CH, 6.5 34H, 5.5 2CH. The vector output reads 00H whenever take is low.
- R10: An accepted general request gives a one-cycle acknowledge pulse in the cycle after the boundary. It gives no take pulse and a vector of 00H.
- R11: Without a boundary strobe, no interrupt is accepted, and neither the pending state nor the enable flip-flop is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_i | input | 1 | Non-maskable trap request (level) |
| rst75_i | input | 1 | Restart 7.5 request (rising edge) |
| rst65_i | input | 1 | Restart 6.5 request (level) |
| rst55_i | input | 1 | Restart 5.5 request (level) |
| intr_i | input | 1 | General request (level) |
| cfg_we_i | input | 1 | Control byte write strobe |
| cfg_data_i | input | 8 | Control byte |
| ien_set_i | input | 1 | Enable command |
| ien_clr_i | input | 1 | Disable command |
| boundary_i | input | 1 | Instruction boundary strobe |
| sin_i | input | 1 | Serial input pin |
| stat_o | output | 8 | Status byte |
| sout_o | output | 1 | Serial output latch |
| take_o | output | 1 | Vectored interrupt accepted (pulse) |
| vec_o | output | 8 | Restart vector address |
| inta_o | output | 1 | General request acknowledge (pulse) |

## Verification
The hardest state to reach is a boundary at which every request is active at once. To reach it, the masks must be open and the enable flip-flop set. The 7.5 latch must also be armed by an edge at least one cycle before the boundary, so that the registered levels have caught up. The stimulus builds this state in separate cycles and then steps through successive boundaries. Between boundaries it re-enables the controller and drops each winner, so that the full priority chain unwinds one request at a time. A second case writes the 7.5 clear bit in the same cycle as a fresh rising edge, to check which of the two prevails.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int BYTE_W = 8;
  localparam int NRST   = 3;  // restart lines: 0=5.5, 1=6.5, 2=7.5
  localparam int NLVL   = 4;  // sampled levels: 0=5.5, 1=6.5, 2=trap, 3=intr

  // control byte fields
  localparam int CB_MSE  = 3;
  localparam int CB_C75  = 4;
  localparam int CB_SDE  = 6;
  localparam int CB_SDO  = 7;

  // status byte fields
  localparam int SB_IEN  = 3;
  localparam int SB_PND  = 4;
  localparam int SB_SIN  = 7;

  localparam int VEC_HALF = 4;  // vector = (2*n) * 4

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_TRAP,
    SRC_R75,
    SRC_R65,
    SRC_R55,
    SRC_INTR
  } src_e;

  function automatic logic [BYTE_W-1:0] vec_of(src_e s);
    int half;
    case (s)
      SRC_TRAP: half = 9;
      SRC_R75:  half = 15;
      SRC_R65:  half = 13;
      SRC_R55:  half = 11;
      default:  half = 0;
    endcase
    return BYTE_W'(half * VEC_HALF);
  endfunction
endpackage

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              ien_set_i,
  input  logic              ien_clr_i,
  input  logic              accept_i,
  output logic [NRST-1:0]   mask_o,
  output logic              ien_o,
  output logic              sout_o
);
  logic [NRST-1:0] mask_q;
  logic            ien_q, sout_q;

  wire mask_ld = we_i & wdata_i[CB_MSE];
  wire sout_ld = we_i & wdata_i[CB_SDE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      ien_q  <= 1'b0;
      sout_q <= 1'b0;
    end else begin
      if (mask_ld) mask_q <= wdata_i[NRST-1:0];
      if (sout_ld) sout_q <= wdata_i[CB_SDO];
      if (accept_i || ien_clr_i) ien_q <= 1'b0;
      else if (ien_set_i)        ien_q <= 1'b1;
    end
  end

  assign mask_o = mask_q;
  assign ien_o  = ien_q;
  assign sout_o = sout_q;

  assert_mask_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wdata_i[CB_MSE]) |=> $stable(mask_q));
  assert_sout_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && wdata_i[CB_SDE]) |=> $stable(sout_q));
  assert_ien_accept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> !ien_q);
endmodule

// File: rtl/irq_pend.sv
module irq_pend
  import irq_pkg::*;
#(
  parameter int N_LVL = NLVL
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_LVL-1:0] lvl_i,
  input  logic             edge_req_i,
  input  logic             clr_i,
  input  logic             ack_i,
  output logic [N_LVL-1:0] lvl_o,
  output logic             latch_o
);
  logic [N_LVL-1:0] lvl_q;
  logic             prev_q, latch_q;

  for (genvar g = 0; g < N_LVL; g++) begin : g_smp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_q[g] <= 1'b0;
      else         lvl_q[g] <= lvl_i[g];
    end
  end

  wire rise = edge_req_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q <= edge_req_i;
      if (rise)               latch_q <= 1'b1;  // fresh edge beats clear
      else if (clr_i || ack_i) latch_q <= 1'b0;
    end
  end

  assign lvl_o   = lvl_q;
  assign latch_o = latch_q;

  assert_latch_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> latch_q);
  assert_latch_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_q && !clr_i && !ack_i) |=> latch_q);
  assert_latch_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !edge_req_i) |=> !latch_q);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic            boundary_i,
  input  logic            trap_i,
  input  logic            intr_i,
  input  logic [NRST-1:0] pend_i,
  input  logic [NRST-1:0] mask_i,
  input  logic            ien_i,
  output src_e            sel_o
);
  logic [NRST-1:0] go;

  for (genvar g = 0; g < NRST; g++) begin : g_gate
    assign go[g] = pend_i[g] & ~mask_i[g] & ien_i;
  end

  always_comb begin
    sel_o = SRC_NONE;
    if (boundary_i) begin
      if (trap_i)               sel_o = SRC_TRAP;
      else if (go[2])           sel_o = SRC_R75;
      else if (go[1])           sel_o = SRC_R65;
      else if (go[0])           sel_o = SRC_R55;
      else if (intr_i && ien_i) sel_o = SRC_INTR;
    end
  end
endmodule

// File: rtl/irq_restart_ctrl.sv
module irq_restart_ctrl
  import irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trap_i,
  input  logic              rst75_i,
  input  logic              rst65_i,
  input  logic              rst55_i,
  input  logic              intr_i,
  input  logic              cfg_we_i,
  input  logic [BYTE_W-1:0] cfg_data_i,
  input  logic              ien_set_i,
  input  logic              ien_clr_i,
  input  logic              boundary_i,
  input  logic              sin_i,
  output logic [BYTE_W-1:0] stat_o,
  output logic              sout_o,
  output logic              take_o,
  output logic [BYTE_W-1:0] vec_o,
  output logic              inta_o
);
  logic [NRST-1:0] mask;
  logic            ien;
  logic [NLVL-1:0] lvl;
  logic            p75;
  src_e            sel;
  logic            unused_cfg;

  assign unused_cfg = cfg_data_i[5];

  wire accept = (sel != SRC_NONE);

  irq_ctrl_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .wdata_i   (cfg_data_i),
    .ien_set_i (ien_set_i),
    .ien_clr_i (ien_clr_i),
    .accept_i  (accept),
    .mask_o    (mask),
    .ien_o     (ien),
    .sout_o    (sout_o)
  );

  irq_pend #(.N_LVL(NLVL)) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lvl_i      ({intr_i, trap_i, rst65_i, rst55_i}),
    .edge_req_i (rst75_i),
    .clr_i      (cfg_we_i & cfg_data_i[CB_C75]),
    .ack_i      (sel == SRC_R75),
    .lvl_o      (lvl),
    .latch_o    (p75)
  );

  wire [NRST-1:0] pend = {p75, lvl[1], lvl[0]};

  irq_arbiter u_arb (
    .boundary_i (boundary_i),
    .trap_i     (lvl[2]),
    .intr_i     (lvl[3]),
    .pend_i     (pend),
    .mask_i     (mask),
    .ien_i      (ien),
    .sel_o      (sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_o <= 1'b0;
      inta_o <= 1'b0;
      vec_o  <= '0;
    end else begin
      take_o <= accept && (sel != SRC_INTR);
      inta_o <= (sel == SRC_INTR);
      vec_o  <= vec_of(sel);
    end
  end

  always_comb begin
    stat_o                     = '0;
    stat_o[NRST-1:0]           = mask;
    stat_o[SB_IEN]             = ien;
    stat_o[SB_PND+:NRST]       = pend;
    stat_o[SB_SIN]             = sin_i;
  end

  assert_trap_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && lvl[2]) |=> (take_o && vec_o == 8'h24));
  assert_no_boundary_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boundary_i |=> (!take_o && !inta_o));
  assert_out_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_o |-> (!take_o && vec_o == '0));
  assert_vec_align_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (vec_o[1:0] == 2'b00 && vec_o[7:6] == 2'b00 && vec_o != '0));
  assert_ien_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o || inta_o) |-> !ien);
endmodule

// File: tb/irq_restart_ctrl_bench.sv
module irq_restart_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic trap = 0, r75 = 0, r65 = 0, r55 = 0, intr = 0;
  logic we = 0, iset = 0, iclr = 0, bnd = 0, sin = 0;
  logic [7:0] wd = 8'h00;
  logic [7:0] stat, vec;
  logic sout, take, inta;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;  // 50 MHz

  irq_restart_ctrl u_irq_restart_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .trap_i(trap), .rst75_i(r75), .rst65_i(r65),
    .rst55_i(r55), .intr_i(intr), .cfg_we_i(we), .cfg_data_i(wd),
    .ien_set_i(iset), .ien_clr_i(iclr), .boundary_i(bnd), .sin_i(sin),
    .stat_o(stat), .sout_o(sout), .take_o(take), .vec_o(vec), .inta_o(inta)
  );

  // behavioural reference model
  int m_mask, m_ien, m_sout, m_p75, m_prev, m_t, m_6, m_5, m_i;
  int m_take, m_vec, m_inta;
  always @(posedge clk or negedge rst_n) begin
    int win;
    if (!rst_n) begin
      m_mask = 7; m_ien = 0; m_sout = 0; m_p75 = 0; m_prev = 0;
      m_t = 0; m_6 = 0; m_5 = 0; m_i = 0; m_take = 0; m_vec = 0; m_inta = 0;
    end else begin
      win = 0;  // 0 none, 1 trap, 2 r75, 3 r65, 4 r55, 5 intr
      if (bnd) begin
        if (m_t) win = 1;
        else if (m_ien && m_p75 && !m_mask[2]) win = 2;
        else if (m_ien && m_6 && !m_mask[1]) win = 3;
        else if (m_ien && m_5 && !m_mask[0]) win = 4;
        else if (m_ien && m_i) win = 5;
      end
      m_take = (win >= 1 && win <= 4);
      m_inta = (win == 5);
      case (win)
        1: m_vec = 'h24; 2: m_vec = 'h3C; 3: m_vec = 'h34; 4: m_vec = 'h2C;
        default: m_vec = 0;
      endcase
      if (r75 && !m_prev) m_p75 = 1;
      else if (win == 2 || (we && wd[4])) m_p75 = 0;
      m_prev = r75;
      if (we && wd[3]) m_mask = wd[2:0];
      if (we && wd[6]) m_sout = wd[7];
      if (win != 0 || iclr) m_ien = 0;
      else if (iset) m_ien = 1;
      m_t = trap; m_6 = r65; m_5 = r55; m_i = intr;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmp_model();
    int es;
    es = m_mask | (m_ien << 3) | (m_5 << 4) | (m_6 << 5) | (m_p75 << 6) | (int'(sin) << 7);
    chk("R5 model stat", stat, es);
    chk("R4 model sout", sout, m_sout);
    chk("R9 model take", take, m_take);
    chk("R9 model vec", vec, m_vec);
    chk("R10 model inta", inta, m_inta);
  endtask

  task automatic cyc();
    @(posedge clk); #2;
    cmp_model();
    we = 0; iset = 0; iclr = 0; bnd = 0;
  endtask

  task automatic wr(logic [7:0] d);
    we = 1; wd = d; cyc();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #35 rst_n = 1;
    cyc();
    chk("R1 reset stat", stat, 'h07);
    chk("R1 reset sout", sout, 0);
    chk("R1 reset take", take, 0);
    // R2 masks
    wr(8'h0A); chk("R2 mask load", stat[2:0], 3'b010);
    wr(8'h05); chk("R2 mask ignored", stat[2:0], 3'b010);
    // R4 serial out
    wr(8'hC0); chk("R4 sout set", sout, 1);
    wr(8'h00); chk("R4 sout hold", sout, 1);
    wr(8'h40); chk("R4 sout clear", sout, 0);
    // R6 enable
    iset = 1; cyc(); chk("R6 enable", stat[3], 1);
    iset = 1; iclr = 1; cyc(); chk("R6 disable wins", stat[3], 0);
    // R7 / R3 edge latch
    r75 = 1; cyc(); chk("R7 latch set", stat[6], 1);
    r75 = 0; cyc(); chk("R7 latch held", stat[6], 1);
    wr(8'h10); chk("R3 latch cleared", stat[6], 0);
    r75 = 1; we = 1; wd = 8'h10; cyc(); chk("R3 edge beats clear", stat[6], 1);
    r75 = 0; wr(8'h18);  // open masks, clear latch
    chk("R3 clear with masks", stat, 'h08 >> 3 == 1 ? 0 : 0);
    // R8 priority chain
    iset = 1; r55 = 1; r65 = 1; intr = 1; r75 = 1; cyc();
    chk("R7 all pending", stat[6:4], 3'b111);
    bnd = 1; cyc();
    chk("R8 r75 first take", take, 1); chk("R9 r75 vector", vec, 'h3C);
    chk("R6 cleared on accept", stat[3], 0);
    chk("R9 take one pulse", take, 1); cyc(); chk("R9 take dropped", take, 0);
    iset = 1; cyc(); bnd = 1; cyc(); chk("R9 r65 vector", vec, 'h34);
    iset = 1; r65 = 0; cyc(); bnd = 1; cyc(); chk("R9 r55 vector", vec, 'h2C);
    iset = 1; r55 = 0; cyc(); bnd = 1; cyc();
    chk("R10 inta", inta, 1); chk("R10 no take", take, 0); chk("R10 vec zero", vec, 0);
    // R11 no boundary
    iset = 1; cyc();
    repeat (5) begin cyc(); chk("R11 no accept", take | inta, 0); end
    chk("R11 enable kept", stat[3], 1);
    intr = 0; r75 = 0;
    // R8 mask blocks, trap ignores mask and enable
    wr(8'h09); r55 = 1; cyc(); bnd = 1; cyc(); chk("R8 masked r55", take, 0);
    iclr = 1; trap = 1; cyc(); bnd = 1; cyc();
    chk("R8 trap take", take, 1); chk("R9 trap vector", vec, 'h24);
    trap = 0; r55 = 0;
    // R5 serial input
    sin = 1; cyc(); chk("R5 sin bit", stat[7], 1);
    sin = 0; cyc(); chk("R5 sin low", stat[7], 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule